// File: doc/BRIEF.md
# Closed-loop supply voltage step controller

This block holds a 7-bit voltage code that feeds an external regulator. In automatic operation it watches two trip indications from a timing monitor. A slow trip means the logic is too slow, so the code is raised. A fast trip means there is margin to spare, so the code is lowered. After every move the block waits a settling time before it acts again. That time is programmed separately for upward and downward moves, each as a prescaler followed by a count.

Software can also place the code at a target value. The target is either applied in one jump or reached step by step, with the same settling wait after each step. The block checks the code against a pair of limits and against a masked low-voltage threshold. It flags simultaneous up and down requests and long runs of moves in one direction. It also handles a low-power request, with an acknowledge that can be gated on idle and an abort that forces the controller to idle.

Top module: `vstep_ctrl`

## Requirements
- R1: After reset the code equals RESET_CODE (64), `state_o` is 0 (idle), and the activity, limit-error, adjust-error, timeout, mirror and acknowledge outputs are 0.
- R2: In the monitor state (`state_o`=1, `adj_en_i`=1), a slow trip alone raises the code and a fast trip alone lowers it. The step is `step_i`, and a step of 0 counts as 1. A raise never passes `lim_hi_i` and a lower never passes `lim_lo_i`. A code that is already at or beyond that limit is held.
- R3: When both trips are high in the monitor state, the code is kept, the state stays 1 and `adj_err_o` sets and stays set until `err_clr_i`.
- R4: Each move enters the settling state (`state_o`=2) for dly*(pre+1)+1 cycles. A raise uses the up prescaler and count and drives `up_act_o`. A lower uses the down pair and drives `dn_act_o`. `dly_ok_o` is 1 exactly when the settling count is zero.
- R5: In idle, a `direct_go_i` pulse with `direct_step_i`=0 sets the code to the target at once. The target is first clamped into [`lim_lo_i`, `lim_hi_i`], and the state stays 0.
- R6: With `direct_step_i`=1 the state goes to 3. The code then moves toward the clamped target by at most the step, settling after each move, until it equals the target and the state returns to 0. `direct_act_o` is high throughout.
- R7: While `sw_lock_i` is 1, `direct_go_i` is ignored and the code stays unchanged.
- R8: `lo_lim_o` is high when code <= `lim_lo_i` and `hi_lim_o` is high when code >= `lim_hi_i`. `lim_err_o` sets on either one and clears on `err_clr_i` only when neither holds.
- R9: `lv_det_o` is high when (code & `lv_mask_i`) < (`lv_thr_i` & `lv_mask_i`). `lv_det_s_o` sets one cycle after and holds until `lv_s_clr_i`.
- R10: A run of TO_STEPS (8) automatic moves in one direction, with a trip present at every return to monitor, sets `to_err_o` and `to_err_s_o` at the eighth move. `err_clr_i` clears only `to_err_o`, and `to_s_clr_i` clears only `to_err_s_o`.
- R11: `irq_o` is the OR of `lim_err_o`, `adj_err_o`, `to_err_o` and `lv_det_s_o`, each gated by its own enable input.
- R12: `lp_ack_o` follows `lp_req_i` one cycle later. When `lp_ack_gate_i` is 1 it rises only if the state was idle in the previous cycle.
- R13: `lp_req_i` together with `lp_abort_i` forces the state to 0 on the next cycle and holds it there while both stay high. The code is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adj_en_i | input | 1 | Enable automatic trip-driven adjustment |
| direct_go_i | input | 1 | Pulse: apply the target in idle |
| direct_step_i | input | 1 | 1: step toward target, 0: jump |
| sw_lock_i | input | 1 | Block software target requests |
| step_i | input | 3 | Step size (0 means 1) |
| slow_trip_i | input | 1 | Monitor reports too slow |
| fast_trip_i | input | 1 | Monitor reports too fast |
| target_i | input | 7 | Direct target code |
| up_pre_i | input | 8 | Prescaler for raise settling |
| up_dly_i | input | 16 | Count for raise settling |
| dn_pre_i | input | 8 | Prescaler for lower settling |
| dn_dly_i | input | 16 | Count for lower settling |
| lim_lo_i | input | 7 | Lower code bound |
| lim_hi_i | input | 7 | Upper code bound |
| lv_thr_i | input | 7 | Low-voltage threshold |
| lv_mask_i | input | 7 | Mask for low-voltage compare |
| lim_ie_i | input | 1 | Interrupt enable, limit error |
| adj_ie_i | input | 1 | Interrupt enable, adjust error |
| to_ie_i | input | 1 | Interrupt enable, timeout |
| lv_ie_i | input | 1 | Interrupt enable, low voltage |
| err_clr_i | input | 1 | Clear limit, adjust and timeout errors |
| to_s_clr_i | input | 1 | Clear timeout mirror |
| lv_s_clr_i | input | 1 | Clear low-voltage mirror |
| lp_req_i | input | 1 | Low-power request |
| lp_ack_gate_i | input | 1 | Acknowledge only from idle |
| lp_abort_i | input | 1 | Force idle on request |
| vcode_o | output | 7 | Voltage code |
| state_o | output | 4 | 0 idle, 1 monitor, 2 settle, 3 direct |
| up_act_o | output | 1 | Settling after a raise |
| dn_act_o | output | 1 | Settling after a lower |
| direct_act_o | output | 1 | Stepped direct adjustment in progress |
| dly_ok_o | output | 1 | Settling count is zero |
| lo_lim_o | output | 1 | Code at or below lower bound |
| hi_lim_o | output | 1 | Code at or above upper bound |
| lim_err_o | output | 1 | Sticky limit error |
| adj_err_o | output | 1 | Sticky simultaneous-trip error |
| to_err_o | output | 1 | Sticky timeout error |
| to_err_s_o | output | 1 | Timeout mirror |
| lv_det_o | output | 1 | Low-voltage condition now |
| lv_det_s_o | output | 1 | Sticky low-voltage mirror |
| irq_o | output | 1 | Gated interrupt |
| lp_ack_o | output | 1 | Low-power acknowledge |

## Verification
Automatic moves are driven by a seeded random mix of raise and lower requests and step sizes, including zero. This separates the step arithmetic, the direction choice and the independent up and down settling pairs. Directed runs push the code onto each limit and then beyond it, to show saturation apart from ordinary steps. Targets below the lower bound and a masked threshold that is equal only after masking separate clamping and masking from a plain compare. Held trips, both trips at once, and low-power requests issued during monitoring and settling cover the timeout, adjust-error, gating and abort rules.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_MON    = 4'd1,
    ST_SETTLE = 4'd2,
    ST_DIRECT = 4'd3
  } vstep_state_e;
endpackage

// File: rtl/vstep_delay.sv
module vstep_delay #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             zero_o
);
  logic [PRE_W-1:0] pre_q, pre_cnt_q;
  logic [DLY_W-1:0] dly_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      pre_cnt_q <= '0;
      dly_cnt_q <= '0;
    end else if (load_i) begin
      pre_q     <= pre_i;
      pre_cnt_q <= pre_i;
      dly_cnt_q <= dly_i;
    end else if (run_i && dly_cnt_q != '0) begin
      if (pre_cnt_q == '0) begin
        pre_cnt_q <= pre_q;
        dly_cnt_q <= dly_cnt_q - 1'b1;
      end else begin
        pre_cnt_q <= pre_cnt_q - 1'b1;
      end
    end
  end

  assign zero_o = (dly_cnt_q == '0);
endmodule

// File: rtl/vstep_stepper.sv
module vstep_stepper #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned STEP_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] lim_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] next_o
);
  localparam int unsigned SUM_W = CODE_W + 1;
  logic [SUM_W-1:0] se, code_x, lim_x, sum, diff;

  always_comb begin
    se     = (step_i == '0) ? SUM_W'(1) : SUM_W'(step_i);
    code_x = SUM_W'(code_i);
    lim_x  = SUM_W'(lim_i);
    sum    = code_x + se;
    diff   = code_x - se;
    if (up_i) begin
      if (code_x >= lim_x)    next_o = code_i;
      else if (sum >= lim_x)  next_o = lim_i;
      else                    next_o = sum[CODE_W-1:0];
    end else begin
      if (code_x <= lim_x)          next_o = code_i;
      else if (code_x <= lim_x + se) next_o = lim_i;
      else                          next_o = diff[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/vstep_flags.sv
module vstep_flags #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] lim_lo_i,
  input  logic [CODE_W-1:0] lim_hi_i,
  input  logic [CODE_W-1:0] lv_thr_i,
  input  logic [CODE_W-1:0] lv_mask_i,
  input  logic              adj_set_i,
  input  logic              to_set_i,
  input  logic              err_clr_i,
  input  logic              to_s_clr_i,
  input  logic              lv_s_clr_i,
  input  logic              lim_ie_i,
  input  logic              adj_ie_i,
  input  logic              to_ie_i,
  input  logic              lv_ie_i,
  output logic              lo_lim_o,
  output logic              hi_lim_o,
  output logic              lim_err_o,
  output logic              adj_err_o,
  output logic              to_err_o,
  output logic              to_err_s_o,
  output logic              lv_det_o,
  output logic              lv_det_s_o,
  output logic              irq_o
);
  assign lo_lim_o = (code_i <= lim_lo_i);
  assign hi_lim_o = (code_i >= lim_hi_i);
  assign lv_det_o = ((code_i & lv_mask_i) < (lv_thr_i & lv_mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_err_o  <= 1'b0;
      adj_err_o  <= 1'b0;
      to_err_o   <= 1'b0;
      to_err_s_o <= 1'b0;
      lv_det_s_o <= 1'b0;
    end else begin
      // set wins over clear
      lim_err_o  <= (lim_err_o & ~err_clr_i) | lo_lim_o | hi_lim_o;
      adj_err_o  <= (adj_err_o & ~err_clr_i) | adj_set_i;
      to_err_o   <= (to_err_o & ~err_clr_i) | to_set_i;
      to_err_s_o <= (to_err_s_o & ~to_s_clr_i) | to_set_i;
      lv_det_s_o <= (lv_det_s_o & ~lv_s_clr_i) | lv_det_o;
    end
  end

  assign irq_o = (lim_ie_i & lim_err_o) | (adj_ie_i & adj_err_o) |
                 (to_ie_i & to_err_o) | (lv_ie_i & lv_det_s_o);
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int unsigned CODE_W     = 7,
  parameter int unsigned STEP_W     = 3,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned DLY_W      = 16,
  parameter int unsigned TO_STEPS   = 8,
  parameter int unsigned RESET_CODE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adj_en_i,
  input  logic              direct_go_i,
  input  logic              direct_step_i,
  input  logic              sw_lock_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              slow_trip_i,
  input  logic              fast_trip_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [PRE_W-1:0]  up_pre_i,
  input  logic [DLY_W-1:0]  up_dly_i,
  input  logic [PRE_W-1:0]  dn_pre_i,
  input  logic [DLY_W-1:0]  dn_dly_i,
  input  logic [CODE_W-1:0] lim_lo_i,
  input  logic [CODE_W-1:0] lim_hi_i,
  input  logic [CODE_W-1:0] lv_thr_i,
  input  logic [CODE_W-1:0] lv_mask_i,
  input  logic              lim_ie_i,
  input  logic              adj_ie_i,
  input  logic              to_ie_i,
  input  logic              lv_ie_i,
  input  logic              err_clr_i,
  input  logic              to_s_clr_i,
  input  logic              lv_s_clr_i,
  input  logic              lp_req_i,
  input  logic              lp_ack_gate_i,
  input  logic              lp_abort_i,
  output logic [CODE_W-1:0] vcode_o,
  output logic [3:0]        state_o,
  output logic              up_act_o,
  output logic              dn_act_o,
  output logic              direct_act_o,
  output logic              dly_ok_o,
  output logic              lo_lim_o,
  output logic              hi_lim_o,
  output logic              lim_err_o,
  output logic              adj_err_o,
  output logic              to_err_o,
  output logic              to_err_s_o,
  output logic              lv_det_o,
  output logic              lv_det_s_o,
  output logic              irq_o,
  output logic              lp_ack_o
);
  localparam int unsigned TO_W = $clog2(TO_STEPS + 1);
  localparam logic [TO_W-1:0] TO_MAX = TO_W'(TO_STEPS);

  vstep_state_e      state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d, tgt_q, tgt_d, tgt_clamp, step_lim, step_next;
  logic              mv_up_q, mv_up_d, from_dir_q, from_dir_d, last_up_q, last_up_d;
  logic [TO_W-1:0]   streak_q, streak_d, streak_inc;
  logic              dir_up, in_direct, abort, direct_req;
  logic              dly_load, dly_zero, adj_set, to_set, lp_ack_q;
  logic [PRE_W-1:0]  ld_pre;
  logic [DLY_W-1:0]  ld_dly;

  assign abort      = lp_req_i & lp_abort_i;
  assign direct_req = direct_go_i & ~sw_lock_i;
  assign in_direct  = (state_q == ST_DIRECT);
  assign dir_up     = in_direct ? (tgt_q > code_q) : slow_trip_i;
  assign step_lim   = in_direct ? tgt_q : (dir_up ? lim_hi_i : lim_lo_i);
  assign ld_pre     = dir_up ? up_pre_i : dn_pre_i;
  assign ld_dly     = dir_up ? up_dly_i : dn_dly_i;
  assign tgt_clamp  = (target_i < lim_lo_i) ? lim_lo_i :
                      (target_i > lim_hi_i) ? lim_hi_i : target_i;

  vstep_stepper #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_stepper (
    .code_i (code_q),
    .lim_i  (step_lim),
    .step_i (step_i),
    .up_i   (dir_up),
    .next_o (step_next)
  );

  vstep_delay #(.PRE_W(PRE_W), .DLY_W(DLY_W)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .run_i  (state_q == ST_SETTLE),
    .pre_i  (ld_pre),
    .dly_i  (ld_dly),
    .zero_o (dly_zero)
  );

  always_comb begin
    state_d    = state_q;
    code_d     = code_q;
    tgt_d      = tgt_q;
    mv_up_d    = mv_up_q;
    from_dir_d = from_dir_q;
    last_up_d  = last_up_q;
    streak_d   = streak_q;
    dly_load   = 1'b0;
    adj_set    = 1'b0;
    to_set     = 1'b0;
    streak_inc = TO_W'(1);
    if (streak_q != '0 && last_up_q == slow_trip_i)
      streak_inc = (streak_q == TO_MAX) ? streak_q : streak_q + 1'b1;

    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (direct_req) begin
            if (direct_step_i) begin
              tgt_d   = tgt_clamp;
              state_d = ST_DIRECT;
            end else begin
              code_d = tgt_clamp;
            end
          end else if (adj_en_i) begin
            state_d  = ST_MON;
            streak_d = '0;
          end
        end
        ST_MON: begin
          if (!adj_en_i) begin
            state_d = ST_IDLE;
          end else if (slow_trip_i && fast_trip_i) begin
            adj_set  = 1'b1;
            streak_d = '0;
          end else if (slow_trip_i || fast_trip_i) begin
            code_d     = step_next;
            mv_up_d    = slow_trip_i;
            from_dir_d = 1'b0;
            dly_load   = 1'b1;
            state_d    = ST_SETTLE;
            last_up_d  = slow_trip_i;
            streak_d   = streak_inc;
            to_set     = (streak_inc == TO_MAX);
          end else begin
            streak_d = '0;
          end
        end
        ST_SETTLE: begin
          if (dly_zero) state_d = from_dir_q ? ST_DIRECT : ST_MON;
        end
        ST_DIRECT: begin
          if (code_q == tgt_q) begin
            state_d = ST_IDLE;
          end else begin
            code_d     = step_next;
            mv_up_d    = dir_up;
            from_dir_d = 1'b1;
            dly_load   = 1'b1;
            state_d    = ST_SETTLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      code_q     <= CODE_W'(RESET_CODE);
      tgt_q      <= CODE_W'(RESET_CODE);
      mv_up_q    <= 1'b0;
      from_dir_q <= 1'b0;
      last_up_q  <= 1'b0;
      streak_q   <= '0;
      lp_ack_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      code_q     <= code_d;
      tgt_q      <= tgt_d;
      mv_up_q    <= mv_up_d;
      from_dir_q <= from_dir_d;
      last_up_q  <= last_up_d;
      streak_q   <= streak_d;
      lp_ack_q   <= lp_req_i & (~lp_ack_gate_i | (state_q == ST_IDLE));
    end
  end

  vstep_flags #(.CODE_W(CODE_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (code_q),
    .lim_lo_i   (lim_lo_i),
    .lim_hi_i   (lim_hi_i),
    .lv_thr_i   (lv_thr_i),
    .lv_mask_i  (lv_mask_i),
    .adj_set_i  (adj_set),
    .to_set_i   (to_set),
    .err_clr_i  (err_clr_i),
    .to_s_clr_i (to_s_clr_i),
    .lv_s_clr_i (lv_s_clr_i),
    .lim_ie_i   (lim_ie_i),
    .adj_ie_i   (adj_ie_i),
    .to_ie_i    (to_ie_i),
    .lv_ie_i    (lv_ie_i),
    .lo_lim_o   (lo_lim_o),
    .hi_lim_o   (hi_lim_o),
    .lim_err_o  (lim_err_o),
    .adj_err_o  (adj_err_o),
    .to_err_o   (to_err_o),
    .to_err_s_o (to_err_s_o),
    .lv_det_o   (lv_det_o),
    .lv_det_s_o (lv_det_s_o),
    .irq_o      (irq_o)
  );

  assign vcode_o      = code_q;
  assign state_o      = state_q;
  assign up_act_o     = (state_q == ST_SETTLE) & mv_up_q;
  assign dn_act_o     = (state_q == ST_SETTLE) & ~mv_up_q;
  assign direct_act_o = in_direct | ((state_q == ST_SETTLE) & from_dir_q);
  assign dly_ok_o     = dly_zero;
  assign lp_ack_o     = lp_ack_q;
endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adj_en_i,
  input logic              sw_lock_i,
  input logic              slow_trip_i,
  input logic              fast_trip_i,
  input logic              lp_req_i,
  input logic              lp_ack_gate_i,
  input logic              lp_abort_i,
  input logic [CODE_W-1:0] vcode_o,
  input logic [3:0]        state_o,
  input logic              up_act_o,
  input logic              dn_act_o,
  input logic              adj_err_o,
  input logic              lp_ack_o
);
  AST_RAISE_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && adj_en_i && slow_trip_i && !fast_trip_i && !(lp_req_i && lp_abort_i))
    |=> (vcode_o >= $past(vcode_o))); // R2
  AST_BOTH_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && adj_en_i && slow_trip_i && fast_trip_i && !(lp_req_i && lp_abort_i))
    |=> (adj_err_o && $stable(vcode_o))); // R3
  AST_ACT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_act_o && dn_act_o)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0 && sw_lock_i) |=> $stable(vcode_o)); // R7
  AST_ACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_ack_o |-> ($past(lp_req_i) && (!$past(lp_ack_gate_i) || $past(state_o) == 4'd0))); // R12
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_req_i && lp_abort_i) |=> (state_o == 4'd0)); // R13
endmodule

bind vstep_ctrl vstep_ctrl_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/vstep_ctrl_tb.sv
module vstep_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic adj_en = 0, direct_go = 0, direct_step = 0, sw_lock = 0;
  logic [2:0] step = 3'd2;
  logic slow_trip = 0, fast_trip = 0;
  logic [6:0] target = 0;
  logic [7:0] up_pre = 8'd1, dn_pre = 8'd0;
  logic [15:0] up_dly = 16'd2, dn_dly = 16'd3;
  logic [6:0] lim_lo = 7'd20, lim_hi = 7'd100, lv_thr = 0, lv_mask = 0;
  logic lim_ie = 1, adj_ie = 1, to_ie = 1, lv_ie = 1;
  logic err_clr = 0, to_s_clr = 0, lv_s_clr = 0;
  logic lp_req = 0, lp_gate = 0, lp_abort = 0;
  logic [6:0] vcode;
  logic [3:0] state;
  logic up_act, dn_act, direct_act, dly_ok, lo_lim, hi_lim, lim_err, adj_err;
  logic to_err, to_err_s, lv_det, lv_det_s, irq, lp_ack;
  int checks = 0, errors = 0, ec = 64;

  always #4 clk = ~clk;

  vstep_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adj_en_i(adj_en), .direct_go_i(direct_go),
    .direct_step_i(direct_step), .sw_lock_i(sw_lock), .step_i(step),
    .slow_trip_i(slow_trip), .fast_trip_i(fast_trip), .target_i(target),
    .up_pre_i(up_pre), .up_dly_i(up_dly), .dn_pre_i(dn_pre), .dn_dly_i(dn_dly),
    .lim_lo_i(lim_lo), .lim_hi_i(lim_hi), .lv_thr_i(lv_thr), .lv_mask_i(lv_mask),
    .lim_ie_i(lim_ie), .adj_ie_i(adj_ie), .to_ie_i(to_ie), .lv_ie_i(lv_ie),
    .err_clr_i(err_clr), .to_s_clr_i(to_s_clr), .lv_s_clr_i(lv_s_clr),
    .lp_req_i(lp_req), .lp_ack_gate_i(lp_gate), .lp_abort_i(lp_abort),
    .vcode_o(vcode), .state_o(state), .up_act_o(up_act), .dn_act_o(dn_act),
    .direct_act_o(direct_act), .dly_ok_o(dly_ok), .lo_lim_o(lo_lim), .hi_lim_o(hi_lim),
    .lim_err_o(lim_err), .adj_err_o(adj_err), .to_err_o(to_err), .to_err_s_o(to_err_s),
    .lv_det_o(lv_det), .lv_det_s_o(lv_det_s), .irq_o(irq), .lp_ack_o(lp_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_raise(int c, int s, int lim);
    int se = (s == 0) ? 1 : s;
    if (c >= lim) return c;
    return (c + se >= lim) ? lim : c + se;
  endfunction

  function automatic int f_lower(int c, int s, int lim);
    int se = (s == 0) ? 1 : s;
    if (c <= lim) return c;
    return (c - se <= lim) ? lim : c - se;
  endfunction

  function automatic bit f_lv(int c, int thr, int mask);
    return (c & mask) < (thr & mask);
  endfunction

  task automatic pulse_clr(ref logic sig);
    sig = 1; @(negedge clk); sig = 0;
  endtask

  // one automatic move from the monitor state, then the full settle period
  task automatic auto_move(input bit up);
    int n, exp_n;
    ec    = up ? f_raise(ec, step, lim_hi) : f_lower(ec, step, lim_lo);
    exp_n = up ? up_dly * (up_pre + 1) + 1 : dn_dly * (dn_pre + 1) + 1;
    slow_trip = up; fast_trip = !up;
    @(negedge clk);
    slow_trip = 0; fast_trip = 0;
    chk(vcode == ec, "R2 code after move", vcode, ec);
    chk(state == 2 && up_act == up && dn_act == !up, "R4 settle flags",
        {state, up_act, dn_act}, {4'd2, up, !up});
    n = 1;
    while (n < 5000) begin
      @(negedge clk);
      if (state != 2) break;
      n++;
    end
    chk(n == exp_n, "R4 settle length", n, exp_n);
    chk(state == 1 && dly_ok, "R4 back to monitor", {state, dly_ok}, {4'd1, 1'b1});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int moves, prev;
    bit seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(vcode == 64 && state == 0, "R1 reset code/state", vcode, 64);
    chk({up_act, dn_act, lim_err, adj_err, to_err, to_err_s, lv_det_s, lp_ack} == 0,
        "R1 reset flags", {up_act, dn_act, lim_err, adj_err, to_err, to_err_s, lv_det_s, lp_ack}, 0);

    adj_en = 1;
    @(negedge clk);
    chk(state == 1, "R2 enter monitor", state, 1);
    auto_move(1);
    auto_move(0);
    chk(dn_dly != 0, "R4 nonzero down delay", dn_dly, 3);

    // R2 random moves and step sizes
    for (int i = 0; i < 24; i++) begin
      step = 3'($urandom % 8);
      auto_move(1'($urandom % 2));
    end

    // R8 upper limit and saturation
    step = 3'd2;
    lim_hi = 7'(ec + 1);
    auto_move(1);
    chk(hi_lim == 1 && vcode == lim_hi, "R8 hi_lim", hi_lim, 1);
    chk(lim_err == 1, "R8 lim_err set", lim_err, 1);
    chk(irq == 1, "R11 irq from limit", irq, 1);
    auto_move(1);
    lim_ie = 0; #1;
    chk(irq == 0, "R11 irq masked", irq, 0);
    lim_hi = 7'd100;
    auto_move(0);
    pulse_clr(err_clr);
    chk(lim_err == 0 && hi_lim == 0, "R8 lim_err clear", lim_err, 0);
    lim_lo = 7'(ec - 1);
    auto_move(0);
    chk(lo_lim == 1 && vcode == lim_lo, "R8 lo_lim", lo_lim, 1);
    auto_move(0);
    lim_lo = 7'd20;
    auto_move(1);
    pulse_clr(err_clr);
    chk(lim_err == 0, "R8 lim_err clear low", lim_err, 0);

    // R3 both trips
    slow_trip = 1; fast_trip = 1;
    @(negedge clk);
    slow_trip = 0; fast_trip = 0;
    chk(vcode == ec && state == 1 && adj_err == 1, "R3 adjust error", {vcode, adj_err}, {7'(ec), 1'b1});
    chk(irq == 1, "R11 irq from adjust error", irq, 1);
    adj_ie = 0; #1;
    chk(irq == 0, "R11 adjust irq masked", irq, 0);
    pulse_clr(err_clr);
    chk(adj_err == 0, "R3 adjust error clear", adj_err, 0);

    // R10 timeout after 8 same-direction moves
    step = 3'd1; lim_hi = 7'd127;
    slow_trip = 1; moves = 0; prev = state;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (state == 2 && prev != 2) moves++;
      prev = state;
      if (to_err) break;
    end
    slow_trip = 0;
    chk(moves == 8 && to_err_s == 1, "R10 timeout at eighth move", moves, 8);
    ec = ec + 8;
    while (state != 1) @(negedge clk);
    chk(vcode == ec, "R10 code after run", vcode, ec);
    chk(irq == 1, "R11 irq from timeout", irq, 1);
    pulse_clr(err_clr);
    chk(to_err == 0 && to_err_s == 1, "R10 err_clr keeps mirror", {to_err, to_err_s}, 1);
    pulse_clr(to_s_clr);
    chk(to_err_s == 0, "R10 mirror clear", to_err_s, 0);
    to_ie = 0; lim_hi = 7'd100;

    // R5 direct jump and clamp
    adj_en = 0;
    @(negedge clk);
    chk(state == 0, "R5 idle", state, 0);
    target = 7'h45; direct_step = 0; direct_go = 1;
    @(negedge clk); direct_go = 0;
    chk(vcode == 7'h45 && state == 0, "R5 jump", vcode, 7'h45);
    target = 7'd5; direct_go = 1;
    @(negedge clk); direct_go = 0;
    chk(vcode == 20, "R5 clamp to low limit", vcode, 20);
    target = 7'h45; direct_go = 1;
    @(negedge clk); direct_go = 0;
    ec = 7'h45;
    // R7 lock
    sw_lock = 1; target = 7'h30; direct_go = 1;
    @(negedge clk); direct_go = 0;
    @(negedge clk); sw_lock = 0;
    chk(vcode == ec && state == 0, "R7 lock ignores target", vcode, ec);

    // R9 low-voltage compare with mask
    lv_mask = 7'h70; lv_thr = 7'h4F; #1;
    chk(lv_det == f_lv(ec, 7'h4F, 7'h70), "R9 masked equal", lv_det, 0);
    lv_thr = 7'h7F; #1;
    chk(lv_det == f_lv(ec, 7'h7F, 7'h70), "R9 below threshold", lv_det, 1);
    @(negedge clk);
    chk(lv_det_s == 1 && irq == 1, "R9 mirror set and R11 irq", lv_det_s, 1);
    lv_thr = 7'h00; #1;
    chk(lv_det == 0 && lv_det_s == 1, "R9 mirror held", lv_det_s, 1);
    pulse_clr(lv_s_clr);
    chk(lv_det_s == 0 && irq == 0, "R9 mirror clear", lv_det_s, 0);

    // R6 stepped direct move
    step = 3'd3; direct_step = 1; target = 7'h20; direct_go = 1;
    @(negedge clk); direct_go = 0;
    chk(state == 3, "R6 direct state", state, 3);
    moves = 0; prev = state; seen = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (state == 2 && prev != 2) moves++;
      if (state != 0 && !direct_act) seen = 0;
      prev = state;
      if (state == 0) break;
    end
    ec = 7'h20;
    chk(vcode == 7'h20 && state == 0, "R6 reached target", vcode, 7'h20);
    chk(moves == 13, "R6 step count", moves, 13);
    chk(seen == 1, "R6 direct_act held", seen, 1);

    // R12 acknowledge gating
    adj_en = 1;
    @(negedge clk);
    lp_req = 1; lp_gate = 1;
    @(negedge clk); @(negedge clk);
    chk(lp_ack == 0, "R12 gated in monitor", lp_ack, 0);
    lp_gate = 0;
    @(negedge clk);
    chk(lp_ack == 1, "R12 ungated ack", lp_ack, 1);
    lp_gate = 1;
    @(negedge clk);
    chk(lp_ack == 0, "R12 gated again", lp_ack, 0);
    adj_en = 0;
    @(negedge clk); @(negedge clk);
    chk(lp_ack == 1 && state == 0, "R12 ack from idle", lp_ack, 1);
    lp_req = 0; lp_gate = 0;

    // R13 abort during settling
    adj_en = 1; up_dly = 16'd100; up_pre = 8'd0;
    @(negedge clk);
    step = 3'd2;
    ec = f_raise(ec, 2, lim_hi);
    slow_trip = 1;
    @(negedge clk); slow_trip = 0;
    chk(state == 2, "R13 settling before abort", state, 2);
    lp_req = 1; lp_abort = 1;
    @(negedge clk);
    chk(state == 0 && vcode == ec, "R13 forced idle", {state, vcode}, {4'd0, 7'(ec)});
    repeat (3) @(negedge clk);
    chk(state == 0, "R13 held idle", state, 0);
    lp_req = 0; lp_abort = 0;
    @(negedge clk);
    chk(state == 1, "R13 resume monitor", state, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule